// File: doc/BRIEF.md
# Bridge Configuration Register Controller

This block holds the bridge-specific part of a PCI-to-PCI bridge configuration header. It covers the bus numbers, the I/O, memory and prefetchable forwarding windows and the bridge control word. A configuration agent writes it with dword writes that carry byte enables, and reads it through a combinational read port indexed by dword. The stored base and limit fields are expanded into full window addresses for a downstream address decoder.

Writes have side effects. A write that touches any byte affecting forwarding raises a one-cycle remap strobe, so the window decoder knows to reload. A write that raises the bus-reset bit in bridge control raises a one-cycle secondary bus reset pulse. A separate disable-forwarding command forces every window into an empty state, with each limit below its base. Synchronous reset returns all writable fields to zero.

Top module: `bridge_cfg_regs`

## Requirements
- R1: After reset, the following read zero: the bus-number dword (0x18), every writable base/limit address bit, the prefetchable upper registers (0x28, 0x2C), the I/O upper registers (0x30) and bridge control. The read-only type nibbles keep their codes, so with the default parameters dword 0x1C reads 0x00A00101 and dword 0x24 reads 0x00010001.
- R2: The primary, secondary and subordinate bus numbers and the secondary latency timer (bytes 0x18 to 0x1B) are fully writable, one byte per enabled lane. Lanes whose enable is low keep their old value.
- R3: In the low bytes of the I/O, memory and prefetchable base and limit registers, only bits 7:4 take written data. Bits 3:0 always read the type code: 0x1 for 32-bit I/O when IO_32=1, 0x1 for 64-bit prefetchable when PREF_64=1, and 0x0 for memory. The upper bytes are fully writable.
- R4: The window outputs are decoded as follows. The I/O base is {I/O upper base, base[7:4], 12'h000} and the I/O limit is {I/O upper limit, limit[7:4], 12'hFFF}. The memory base is {reg[15:4], 20'h00000} and the memory limit is {reg[15:4], 20'hFFFFF}. The prefetchable window is decoded the same way as memory, with the upper 32-bit registers on top.
- R5: remap_pulse is high for exactly one cycle, in the cycle after the write is taken, in two cases. The first is a write that enables a byte in 0x04 to 0x05, 0x1C to 0x1D, 0x20 to 0x33 or 0x3E to 0x3F. The second is a disable-forwarding command. A write touching only other bytes (for example 0x18 to 0x1B, 0x1E, 0x3C to 0x3D, 0x06) gives no strobe.
- R6: sec_bus_reset is high for one cycle, in the cycle after a write that sets bridge control bit 6 (byte 0x3E, bit 6) while it was 0. Writing 1 when it is already 1, or writing 0, gives no pulse.
- R7: A disable-forwarding command has four effects. It sets all address bits of the I/O, memory and prefetchable base registers to one. It clears all address bits of the matching limit registers. It zeroes the prefetchable upper base and limit. It leaves the I/O upper registers and bus numbers unchanged. On those bytes it wins over a write in the same cycle, while the other bytes of that write are accepted.
- R8: Dword 0x04 reads 0x00A00000: the status word reports 66 MHz capability (bit 5) and fast back-to-back capability (bit 7), and the command word is not stored. Dword 0x0C carries the header type in byte 2 as {MULTI_FN, 7'h01}. The secondary status (0x1E) reads 0x00A0 and ignores writes.
- R9: Unimplemented locations read zero and ignore writes. This covers dwords 0x00, 0x08 and 0x10 to 0x14, bytes 0x34 to 0x3D and bridge control bits 15:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write request, taken on the rising edge |
| cfg_addr | input | ADDR_W | Dword index for read and write |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| fwd_disable | input | 1 | Disable-forwarding command, one cycle |
| remap_pulse | output | 1 | Window remap strobe |
| sec_bus_reset | output | 1 | Secondary bus reset pulse |
| bus_pri | output | 8 | Primary bus number |
| bus_sec | output | 8 | Secondary bus number |
| bus_sub | output | 8 | Subordinate bus number |
| io_win_base | output | 32 | Decoded I/O window base |
| io_win_limit | output | 32 | Decoded I/O window limit |
| mem_win_base | output | 32 | Decoded memory window base |
| mem_win_limit | output | 32 | Decoded memory window limit |
| pref_win_base | output | 64 | Decoded prefetchable window base |
| pref_win_limit | output | 64 | Decoded prefetchable window limit |
| bridge_ctl | output | 16 | Bridge control word |

## Verification
The remap strobe and the secondary bus reset pulse fall in the same cycle whenever bridge control is written with the bus-reset bit rising. The bench provokes this with a byte-enabled write to 0x3E and judges both outputs in the one cycle after the write, then checks that both are low in the next cycle. A disable-forwarding command can also meet a configuration write in the same cycle. The bench issues both together in three ways: against the memory base/limit dword, where the disable values must win; against the bus-number dword, which must take the written data; and against a bus-reset write, which must still produce both pulses.

// File: rtl/bcr_pkg.sv
// Shared definitions for the bridge configuration register controller.
// Assumes byte offsets within a 256-byte configuration space.
package bcr_pkg;
    localparam int CFG_FIRST = 8'h18;   // first stored byte
    localparam int CFG_NB    = 40;      // stored bytes, 0x18..0x3F

    typedef enum logic [1:0] {DK_NONE, DK_SET, DK_CLR} dis_kind_e;

    // Writable bit mask of a stored byte
    function automatic logic [7:0] byte_wmask(int off, bit io32, bit pref64);
        if (off >= 8'h18 && off <= 8'h1B) return 8'hFF;
        if (off == 8'h1C || off == 8'h1D) return 8'hF0;
        if (off == 8'h20 || off == 8'h22 || off == 8'h24 || off == 8'h26) return 8'hF0;
        if (off == 8'h21 || off == 8'h23 || off == 8'h25 || off == 8'h27) return 8'hFF;
        if (off >= 8'h28 && off <= 8'h2F) return pref64 ? 8'hFF : 8'h00;
        if (off >= 8'h30 && off <= 8'h33) return io32 ? 8'hFF : 8'h00;
        if (off == 8'h3E) return 8'hFF;
        if (off == 8'h3F) return 8'h0F;
        return 8'h00;
    endfunction

    // Fixed read-only bits of a stored byte
    function automatic logic [7:0] byte_roval(int off, bit io32, bit pref64);
        if (off == 8'h1C || off == 8'h1D) return io32 ? 8'h01 : 8'h00;
        if (off == 8'h24 || off == 8'h26) return pref64 ? 8'h01 : 8'h00;
        if (off == 8'h1E) return 8'hA0;
        return 8'h00;
    endfunction

    // Action of the disable-forwarding command on a stored byte
    function automatic dis_kind_e byte_dkind(int off);
        if (off == 8'h1C || off == 8'h20 || off == 8'h21 ||
            off == 8'h24 || off == 8'h25) return DK_SET;
        if (off == 8'h1D || off == 8'h22 || off == 8'h23 ||
            off == 8'h26 || off == 8'h27) return DK_CLR;
        if (off >= 8'h28 && off <= 8'h2F) return DK_CLR;
        return DK_NONE;
    endfunction

    // True when a written byte affects forwarding windows
    function automatic logic fwd_byte(logic [7:0] off);
        return (off == 8'h04) || (off == 8'h05) || (off == 8'h1C) ||
               (off == 8'h1D) || (off >= 8'h20 && off <= 8'h33) ||
               (off == 8'h3E) || (off == 8'h3F);
    endfunction
endpackage

// File: rtl/bcr_byte_cell.sv
// One configuration byte: writable bits, fixed bits, disable action.
// Assumes we and wd are already decoded for this byte.
module bcr_byte_cell
    import bcr_pkg::*;
#(
    parameter logic [7:0] WMASK = 8'hFF,
    parameter logic [7:0] ROVAL = 8'h00,
    parameter dis_kind_e  DKIND = DK_NONE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wd,
    input  logic       dis,
    output logic [7:0] rd
);
    logic [7:0] q;

    // Store writable bits; disable overrides a write on affected bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 8'h00;
        end else if (dis && DKIND == DK_SET) begin
            q <= WMASK;
        end else if (dis && DKIND == DK_CLR) begin
            q <= 8'h00;
        end else if (we) begin
            q <= wd & WMASK;
        end
    end

    // Merge stored bits with fixed ones
    assign rd = (q & WMASK) | ROVAL;
endmodule

// File: rtl/bcr_regfile.sv
// Stored bridge header bytes 0x18..0x3F with per-byte write decode.
// Assumes cfg_addr is a dword index and cfg_be a lane mask.
module bcr_regfile
    import bcr_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter bit IO_32   = 1'b1,
    parameter bit PREF_64 = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [3:0]            cfg_be,
    input  logic [31:0]           cfg_wdata,
    input  logic                  fwd_disable,
    output logic [CFG_NB*8-1:0]   cfg_bytes
);
    for (genvar i = 0; i < CFG_NB; i++) begin : g_byte
        localparam int OFF  = CFG_FIRST + i;
        localparam int LANE = OFF % 4;
        localparam int DW   = OFF / 4;
        logic we;

        // Byte write enable: address match and lane enabled
        assign we = cfg_wr && (cfg_addr == ADDR_W'(DW)) && cfg_be[LANE];

        bcr_byte_cell #(
            .WMASK(byte_wmask(OFF, IO_32, PREF_64)),
            .ROVAL(byte_roval(OFF, IO_32, PREF_64)),
            .DKIND(byte_dkind(OFF))
        ) u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (we),
            .wd   (cfg_wdata[LANE*8 +: 8]),
            .dis  (fwd_disable),
            .rd   (cfg_bytes[i*8 +: 8])
        );
    end
endmodule

// File: rtl/bcr_event_gen.sv
// Registered side-effect pulses: remap strobe and secondary bus reset.
// Assumes ctl_cur is the stored bus-reset bit before the write lands.
module bcr_event_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic remap_req,
    input  logic ctl_we,
    input  logic ctl_new,
    input  logic ctl_cur,
    output logic remap_pulse,
    output logic sec_rst_pulse
);
    // Register both pulses one cycle after the triggering write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remap_pulse   <= 1'b0;
            sec_rst_pulse <= 1'b0;
        end else begin
            remap_pulse   <= remap_req;
            sec_rst_pulse <= ctl_we && ctl_new && !ctl_cur;
        end
    end

    // A reset pulse cannot repeat: the bit must fall before it can rise again
    assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_rst_pulse |=> !sec_rst_pulse);
endmodule

// File: rtl/bridge_cfg_regs.sv
// Bridge configuration register controller top.
// Holds the bridge header fields, decodes the forwarding windows and
// issues remap and secondary bus reset pulses on writes.
// Assumes ADDR_W >= 6 and single-cycle write requests.
module bridge_cfg_regs
    import bcr_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter bit IO_32    = 1'b1,
    parameter bit PREF_64  = 1'b1,
    parameter bit MULTI_FN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              fwd_disable,
    output logic              remap_pulse,
    output logic              sec_bus_reset,
    output logic [7:0]        bus_pri,
    output logic [7:0]        bus_sec,
    output logic [7:0]        bus_sub,
    output logic [31:0]       io_win_base,
    output logic [31:0]       io_win_limit,
    output logic [31:0]       mem_win_base,
    output logic [31:0]       mem_win_limit,
    output logic [63:0]       pref_win_base,
    output logic [63:0]       pref_win_limit,
    output logic [15:0]       bridge_ctl
);
    localparam int FIRST_DW = CFG_FIRST / 4;
    localparam int NUM_DW   = CFG_NB / 4;
    localparam int BYTE_AW  = ADDR_W + 2;
    localparam int CTL_DW   = 8'h3E / 4;
    localparam int CTL_LANE = 8'h3E % 4;
    localparam logic [31:0] STATUS_DW = 32'h00A0_0000;
    localparam logic [31:0] HDR_DW    = {8'h00, MULTI_FN, 7'h01, 16'h0000};

    logic [CFG_NB*8-1:0] cfg_bytes;
    logic [3:0]          lane_fwd;
    logic                remap_req;
    logic                ctl_we;

    // Byte accessor for the stored header
    function automatic logic [7:0] hb(logic [CFG_NB*8-1:0] v, int off);
        return v[(off - CFG_FIRST)*8 +: 8];
    endfunction

    bcr_regfile #(.ADDR_W(ADDR_W), .IO_32(IO_32), .PREF_64(PREF_64)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_be     (cfg_be),
        .cfg_wdata  (cfg_wdata),
        .fwd_disable(fwd_disable),
        .cfg_bytes  (cfg_bytes)
    );

    // Per-lane flag: enabled byte lies in a forwarding-relevant range
    for (genvar l = 0; l < 4; l++) begin : g_lane
        logic [BYTE_AW-1:0] baddr;
        assign baddr       = {cfg_addr, 2'(l)};
        assign lane_fwd[l] = cfg_be[l] && fwd_byte(8'(baddr));
    end

    // Remap request from relevant write or disable command
    assign remap_req = (cfg_wr && |lane_fwd) || fwd_disable;
    // Bridge-control low byte is being written
    assign ctl_we    = cfg_wr && (cfg_addr == ADDR_W'(CTL_DW)) && cfg_be[CTL_LANE];

    bcr_event_gen u_evt (
        .clk          (clk),
        .rst_n        (rst_n),
        .remap_req    (remap_req),
        .ctl_we       (ctl_we),
        .ctl_new      (cfg_wdata[CTL_LANE*8 + 6]),
        .ctl_cur      (bridge_ctl[6]),
        .remap_pulse  (remap_pulse),
        .sec_rst_pulse(sec_bus_reset)
    );

    // Read mux over stored dwords and fixed header words
    always_comb begin
        cfg_rdata = 32'h0;
        if (cfg_addr == ADDR_W'(1)) cfg_rdata = STATUS_DW;
        if (cfg_addr == ADDR_W'(3)) cfg_rdata = HDR_DW;
        for (int d = 0; d < NUM_DW; d++) begin
            if (cfg_addr == ADDR_W'(FIRST_DW + d)) cfg_rdata = cfg_bytes[d*32 +: 32];
        end
    end

    // Bus numbers and control presented to neighbours
    assign bus_pri    = hb(cfg_bytes, 8'h18);
    assign bus_sec    = hb(cfg_bytes, 8'h19);
    assign bus_sub    = hb(cfg_bytes, 8'h1A);
    assign bridge_ctl = {hb(cfg_bytes, 8'h3F), hb(cfg_bytes, 8'h3E)};

    // Window decode: base fills low bits with zeros, limit with ones
    assign io_win_base    = {hb(cfg_bytes, 8'h31), hb(cfg_bytes, 8'h30),
                             hb(cfg_bytes, 8'h1C)[7:4], 12'h000};
    assign io_win_limit   = {hb(cfg_bytes, 8'h33), hb(cfg_bytes, 8'h32),
                             hb(cfg_bytes, 8'h1D)[7:4], 12'hFFF};
    assign mem_win_base   = {hb(cfg_bytes, 8'h21), hb(cfg_bytes, 8'h20)[7:4], 20'h00000};
    assign mem_win_limit  = {hb(cfg_bytes, 8'h23), hb(cfg_bytes, 8'h22)[7:4], 20'hFFFFF};
    assign pref_win_base  = {hb(cfg_bytes, 8'h2B), hb(cfg_bytes, 8'h2A),
                             hb(cfg_bytes, 8'h29), hb(cfg_bytes, 8'h28),
                             hb(cfg_bytes, 8'h25), hb(cfg_bytes, 8'h24)[7:4], 20'h00000};
    assign pref_win_limit = {hb(cfg_bytes, 8'h2F), hb(cfg_bytes, 8'h2E),
                             hb(cfg_bytes, 8'h2D), hb(cfg_bytes, 8'h2C),
                             hb(cfg_bytes, 8'h27), hb(cfg_bytes, 8'h26)[7:4], 20'hFFFFF};

    // After a disable command every window is empty
    assert_dis_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_disable |=> (mem_win_limit < mem_win_base) &&
                        (pref_win_limit < pref_win_base) &&
                        (io_win_limit[15:0] < io_win_base[15:0]));

    // A reset pulse leaves the bus-reset bit set
    assert_rst_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_bus_reset |-> bridge_ctl[6]);

    // A remap strobe always follows a write or disable request
    assert_remap_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        remap_pulse |-> $past(cfg_wr || fwd_disable));

    // Memory window decode relation
    assert_mem_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_win_base[19:0] == 20'h0) && (mem_win_limit[19:0] == 20'hFFFFF));
endmodule

// File: tb/sim_bridge_cfg_regs.sv
module sim_bridge_cfg_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        fwd_disable = 1'b0;
    logic        remap_pulse, sec_bus_reset;
    logic [7:0]  bus_pri, bus_sec, bus_sub;
    logic [31:0] io_win_base, io_win_limit, mem_win_base, mem_win_limit;
    logic [63:0] pref_win_base, pref_win_limit;
    logic [15:0] bridge_ctl;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bridge_cfg_regs u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .fwd_disable(fwd_disable), .remap_pulse(remap_pulse),
        .sec_bus_reset(sec_bus_reset), .bus_pri(bus_pri), .bus_sec(bus_sec),
        .bus_sub(bus_sub), .io_win_base(io_win_base), .io_win_limit(io_win_limit),
        .mem_win_base(mem_win_base), .mem_win_limit(mem_win_limit),
        .pref_win_base(pref_win_base), .pref_win_limit(pref_win_limit),
        .bridge_ctl(bridge_ctl)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Write one dword; returns the pulses seen in the cycle after
    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d,
                      input logic dis, output logic rp, output logic sr);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d; fwd_disable = dis;
        @(negedge clk);
        cfg_wr = 1'b0; fwd_disable = 1'b0; cfg_be = 4'h0;
        rp = remap_pulse; sr = sec_bus_reset;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 ctl", bridge_ctl, 0);
        chk("R1 remap", remap_pulse, 0);
        rd(6'h06, d); chk("R1 bus dword", d, 32'h0);
        rd(6'h07, d); chk("R1 io dword", d, 32'h00A00101);
        rd(6'h09, d); chk("R1 pref dword", d, 32'h00010001);
        rd(6'h0A, d); chk("R1 pref upper", d, 32'h0);
        rd(6'h0C, d); chk("R1 io upper", d, 32'h0);
        rd(6'h01, d); chk("R8 status", d, 32'h00A00000);
        rd(6'h03, d); chk("R8 header", d, 32'h00010000);
        rd(6'h00, d); chk("R9 dword0", d, 32'h0);
    endtask

    task automatic t_bus;
        logic [31:0] d; logic rp, sr;
        wr(6'h06, 4'hF, 32'h40302010, 0, rp, sr);
        chk("R5 no remap bus", rp, 0);
        rd(6'h06, d); chk("R2 bus all", d, 32'h40302010);
        chk("R2 pri", bus_pri, 8'h10); chk("R2 sub", bus_sub, 8'h30);
        wr(6'h06, 4'h2, 32'hAAAAAAAA, 0, rp, sr);
        rd(6'h06, d); chk("R2 one lane", d, 32'h4030AA10);
        chk("R2 sec", bus_sec, 8'hAA);
    endtask

    task automatic t_windows;
        logic [31:0] d; logic rp, sr;
        wr(6'h07, 4'hF, 32'hFFFF5A3F, 0, rp, sr);
        chk("R5 remap io", rp, 1);
        @(negedge clk); chk("R5 single cycle", remap_pulse, 0);
        rd(6'h07, d); chk("R3 io type bits", d, 32'h00A05131);
        chk("R4 io base", io_win_base, 32'h00003000);
        chk("R4 io limit", io_win_limit, 32'h00005FFF);
        wr(6'h0C, 4'hF, 32'h00020001, 0, rp, sr);
        chk("R5 remap io upper", rp, 1);
        chk("R4 io base up", io_win_base, 32'h00013000);
        chk("R4 io limit up", io_win_limit, 32'h00025FFF);
        wr(6'h08, 4'hF, 32'h1239ABCF, 0, rp, sr);
        rd(6'h08, d); chk("R3 mem", d, 32'h1230ABC0);
        chk("R4 mem base", mem_win_base, 32'hABC00000);
        chk("R4 mem limit", mem_win_limit, 32'h123FFFFF);
        wr(6'h09, 4'hF, 32'hFEDF0100, 0, rp, sr);
        rd(6'h09, d); chk("R3 pref type", d, 32'hFED10101);
        wr(6'h0A, 4'hF, 32'h00000007, 0, rp, sr);
        wr(6'h0B, 4'hF, 32'h00000009, 0, rp, sr);
        chk("R4 pref base", pref_win_base, 64'h00000007_01000000);
        chk("R4 pref limit", pref_win_limit, 64'h00000009_FEDFFFFF);
        wr(6'h07, 4'h4, 32'h00FF0000, 0, rp, sr);
        chk("R5 no remap sec status", rp, 0);
        rd(6'h07, d); chk("R8 sec status ro", d, 32'h00A05131);
        wr(6'h01, 4'h1, 32'h00000007, 0, rp, sr);
        chk("R5 remap command", rp, 1);
        rd(6'h01, d); chk("R8 command not held", d, 32'h00A00000);
        wr(6'h01, 4'h4, 32'h00FF0000, 0, rp, sr);
        chk("R5 no remap status", rp, 0);
    endtask

    task automatic t_ctl;
        logic [31:0] d; logic rp, sr;
        wr(6'h0F, 4'h4, 32'h00400000, 0, rp, sr);
        chk("R6 rise pulse", sr, 1); chk("R5 remap ctl", rp, 1);
        chk("R6 ctl", bridge_ctl, 16'h0040);
        @(negedge clk);
        chk("R6 pulse ends", sec_bus_reset, 0); chk("R5 remap ends", remap_pulse, 0);
        wr(6'h0F, 4'h4, 32'h00400000, 0, rp, sr);
        chk("R6 already set", sr, 0); chk("R5 remap ctl again", rp, 1);
        wr(6'h0F, 4'h4, 32'h00000000, 0, rp, sr);
        chk("R6 write zero", sr, 0);
        wr(6'h0F, 4'h4, 32'h00400000, 0, rp, sr);
        chk("R6 rise again", sr, 1);
        wr(6'h0F, 4'h8, 32'hFF000000, 0, rp, sr);
        chk("R9 ctl high bits", bridge_ctl, 16'h0F40); chk("R6 upper byte", sr, 0);
        wr(6'h0F, 4'h3, 32'h0000FFFF, 0, rp, sr);
        chk("R5 no remap 3c", rp, 0);
        rd(6'h0F, d); chk("R9 3c reads zero", d, 32'h0F400000);
        wr(6'h0F, 4'h4, 32'h00000000, 0, rp, sr);
        wr(6'h0D, 4'hF, 32'hFFFFFFFF, 0, rp, sr);
        rd(6'h0D, d); chk("R9 0x34 ignored", d, 32'h0);
    endtask

    task automatic t_disable;
        logic [31:0] d; logic rp, sr;
        @(negedge clk); fwd_disable = 1'b1;
        @(negedge clk); fwd_disable = 1'b0;
        chk("R5 remap on disable", remap_pulse, 1);
        rd(6'h07, d); chk("R7 io", d, 32'h00A001F1);
        rd(6'h08, d); chk("R7 mem", d, 32'h0000FFF0);
        rd(6'h09, d); chk("R7 pref", d, 32'h0001FFF1);
        rd(6'h0A, d); chk("R7 pref up base", d, 32'h0);
        rd(6'h0B, d); chk("R7 pref up limit", d, 32'h0);
        rd(6'h0C, d); chk("R7 io upper kept", d, 32'h00020001);
        rd(6'h06, d); chk("R7 bus kept", d, 32'h4030AA10);
        chk("R7 mem empty", mem_win_limit < mem_win_base, 1);
        chk("R7 pref empty", pref_win_limit < pref_win_base, 1);
        // collisions of disable with writes
        wr(6'h08, 4'hF, 32'h1239ABCF, 0, rp, sr);
        wr(6'h08, 4'hF, 32'h55555555, 1, rp, sr);
        rd(6'h08, d); chk("R7 disable wins", d, 32'h0000FFF0);
        wr(6'h06, 4'hF, 32'h01020304, 1, rp, sr);
        rd(6'h06, d); chk("R7 other bytes taken", d, 32'h01020304);
        wr(6'h0F, 4'h4, 32'h00400000, 1, rp, sr);
        chk("R6 rise with disable", sr, 1); chk("R5 remap with disable", rp, 1);
        chk("R6 ctl with disable", bridge_ctl, 16'h0F40);
    endtask

    task automatic t_rerst;
        logic [31:0] d;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 ctl after reset", bridge_ctl, 0);
        rd(6'h06, d); chk("R1 bus after reset", d, 32'h0);
        rd(6'h07, d); chk("R1 io after reset", d, 32'h00A00101);
        rd(6'h0C, d); chk("R1 io upper after reset", d, 32'h0);
        rd(6'h09, d); chk("R1 pref after reset", d, 32'h00010001);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 no remap in reset", remap_pulse, 0);
        rst_n = 1'b1;
        t_reset();
        t_bus();
        t_windows();
        t_ctl();
        t_disable();
        t_rerst();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule